// File: doc/BRIEF.md
# Per-Pin Interrupt-On-Change Controller

This block watches a parameterised input port (8 pins by default) and raises a single interrupt request when an enabled pin shows a selected transition. Each pin has its own rising-transition enable and falling-transition enable, so a pin can respond to rising, falling or both transitions independently of the others. A qualifying transition sets a sticky per-pin flag, and software can read which pin caused the request straight from the flag register. The flag holds even when a very short pulse has already returned to its old level.

Software reaches the block through a synchronous write port and a synchronous read port. The register addresses are 0 for the port level, 1 for the rising mask, 2 for the falling mask and 3 for the flags. A global enable input gates the request. A legacy mode can be selected for comparison. In that mode the request comes from a level mismatch between the pins and a snapshot that every port access reloads. This mismatch is not latched, and the summary flag is cleared in a separate step. Both behaviours are reproduced on purpose, including the way an event can be lost between the two clearing steps.

Top module: `ioc_ctrl`

## Requirements
- R1: In edge mode (`legacy_mode`=0), a 0→1 transition on pin i sets flag bit i only when bit i of the rising mask (address 1) is 1. The flag becomes visible after the third rising clock edge that follows the change.
- R2: In edge mode, a 1→0 transition on pin i sets flag bit i only when bit i of the falling mask (address 2) is 1. A pin with both bits set flags both transitions, and each pin is configured on its own.
- R3: A read of address 3 in edge mode returns the per-pin flags, with bit i belonging to pin i.
- R4: A flag stays set after its pin returns to the earlier level, including after a pulse lasting a single clock period.
- R5: Writing address 3 clears every flag bit written as 1 and leaves the others alone. If a qualifying transition and a clear reach the same bit at the same clock edge, the bit ends up set.
- R6: `irq` equals `irq_en` AND the OR of all active flags. It stays high until every set flag has been cleared.
- R7: After reset, both masks, the flags, the legacy summary flag and `rd_data` are zero, and the snapshot is loaded from the synchronised pins. As a result `irq` stays low.
- R8: In legacy mode, any bit where the synchronised pins differ from the snapshot, masked by (rising mask OR falling mask), sets the summary flag whatever the direction. Address 3 reads back the summary flag in bit 0 and zero in the other bits, and `irq` follows it.
- R9: In legacy mode the mismatch is not latched. A read or a write of address 0 reloads the snapshot from the synchronised pins. Clearing the summary flag succeeds only while no mismatch remains.
- R10: In legacy mode, suppose the port is read and a short change then comes and goes before the summary flag is cleared. That change leaves no trace: after the clear, `irq` is low and the flag reads 0.
- R11: A read is registered. `rd_data` takes the addressed value at the clock edge where `rd_en` is high and holds otherwise. Address 0 returns the synchronised pin levels, and addresses 1 and 2 return the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | WIDTH | Asynchronous input pins |
| legacy_mode | input | 1 | 1 selects the mismatch mode, 0 selects edge mode |
| irq_en | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 port, 1 rising mask, 2 falling mask, 3 flags) |
| wr_data | input | WIDTH | Write data; a 1 clears the matching flag at address 3 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | WIDTH | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things: a flag never rises without a qualifying transition, a flag only falls when it is cleared, a set wins over a clear, and the legacy summary follows any mismatch. They also check that a port access reloads the snapshot and that `rd_data` holds while no read is issued. Other behaviours can only be shown by the bench's scenarios: the exact per-pin direction selection, a single-cycle pulse being kept, and `irq` staying high until the last flag is cleared. The same holds for a legacy clear failing while a mismatch remains, and for the lost change between a port read and a summary clear. A behavioural model running alongside covers all of these, and it is compared with `irq` and `rd_data` on every clock.

// File: rtl/ioc_pkg.sv
// Package: register addresses shared by the controller and its bench.
// Assumes a two-bit address space with four registers.
package ioc_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT = 2'd0,
        REG_RISE = 2'd1,
        REG_FALL = 2'd2,
        REG_FLAG = 2'd3
    } ioc_reg_e;
endpackage

// File: rtl/ioc_sync.sv
// Module: multi-stage synchroniser with a one-cycle delayed copy.
// Assumes the pins are asynchronous. The chain has no reset, so sampling
// continues during reset and the delayed copy already matches the level when
// reset is released.
module ioc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] level_d
);
    logic [WIDTH-1:0] chain [STAGES];

    // first stage samples the raw pins
    always_ff @(posedge clk) begin
        chain[0] <= din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // each further stage re-registers the previous one
            always_ff @(posedge clk) begin
                chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign level = chain[STAGES-1];

    // previous synchronised level, used for transition detection
    always_ff @(posedge clk) begin
        level_d <= level;
    end
endmodule

// File: rtl/ioc_edge_flags.sv
// Module: per-pin transition qualification and sticky write-1-to-clear flags.
// Assumes level and level_d come from the synchroniser. A set takes priority
// over a clear on the same bit.
module ioc_edge_flags #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] level_d,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] set_vec;

    // qualify rising and falling transitions against their masks
    always_comb begin
        set_vec = '0;
        if (en) begin
            set_vec = (level & ~level_d & rise_en) | (~level & level_d & fall_en);
        end
    end

    // sticky flags: clear first, then set, so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_vec;
    end

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0)); // R1
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags) & ~$past(clr) & ~flags) == '0)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R5
endmodule

// File: rtl/ioc_legacy.sv
// Module: legacy mismatch detector with a snapshot and a summary flag.
// Assumes the reload strobe marks a port access. The mismatch itself is not
// stored, and the summary flag is cleared independently of the snapshot.
module ioc_legacy #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] mask,
    input  logic             reload,
    input  logic             clr,
    output logic             sum
);
    logic [WIDTH-1:0] snap;
    logic [WIDTH-1:0] mismatch;

    // live, unlatched difference between the pins and the snapshot
    assign mismatch = (level ^ snap) & mask;

    // snapshot follows the pins at reset and on every port access
    always_ff @(posedge clk) begin
        if (!rst_n || reload) snap <= level;
    end

    // summary flag: set by any mismatch, cleared by its own write
    always_ff @(posedge clk) begin
        if (!rst_n) sum <= 1'b0;
        else        sum <= (sum & ~clr) | (en & (|mismatch));
    end

    AST_SNAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (snap == $past(level))); // R9
    AST_SUM_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (mismatch != '0)) |=> sum); // R8
endmodule

// File: rtl/ioc_ctrl.sv
// Module: top of the interrupt-on-change controller. It holds the mask
// registers and the read path, and it selects edge or legacy mode.
// Assumes software does not read and write in the same cycle, and changes
// the mode only while irq_en is low.
module ioc_ctrl
    import ioc_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  pin_in,
    input  logic              legacy_mode,
    input  logic              irq_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              irq
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] level, level_d;
    logic [WIDTH-1:0] rise_en, fall_en, flags, clr_vec, flag_view;
    logic             sum, port_access;

    ioc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .din(pin_in), .level(level), .level_d(level_d)
    );

    // write-1-to-clear vector for the flag register
    assign clr_vec = (wr_en && wr_addr == REG_FLAG) ? wr_data : ZERO;

    // a read or write of the port register reloads the legacy snapshot
    assign port_access = (wr_en && wr_addr == REG_PORT) || (rd_en && rd_addr == REG_PORT);

    ioc_edge_flags #(.WIDTH(WIDTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .en(!legacy_mode),
        .level(level), .level_d(level_d),
        .rise_en(rise_en), .fall_en(fall_en),
        .clr(clr_vec), .flags(flags)
    );

    ioc_legacy #(.WIDTH(WIDTH)) u_legacy (
        .clk(clk), .rst_n(rst_n), .en(legacy_mode),
        .level(level), .mask(rise_en | fall_en),
        .reload(port_access), .clr(clr_vec[0]), .sum(sum)
    );

    // mask registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_RISE) rise_en <= wr_data;
            if (wr_addr == REG_FALL) fall_en <= wr_data;
        end
    end

    // flag register as software sees it in the current mode
    assign flag_view = legacy_mode ? {{(WIDTH-1){1'b0}}, sum} : flags;

    // registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) begin
            unique case (ioc_reg_e'(rd_addr))
                REG_PORT: rd_data <= level;
                REG_RISE: rd_data <= rise_en;
                REG_FALL: rd_data <= fall_en;
                REG_FLAG: rd_data <= flag_view;
            endcase
        end
    end

    // single request line gated by the global enable
    assign irq = irq_en && (flag_view != ZERO);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R11
endmodule

// File: tb/ioc_ctrl_bench.sv
module ioc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic       legacy_mode = 1'b0;
    logic       irq_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ioc_ctrl u_ioc_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .legacy_mode(legacy_mode),
        .irq_en(irq_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // behavioural reference model: pin history queue and register variables
    logic [7:0] hist [$] = '{8'h00, 8'h00, 8'h00};
    logic [7:0] m_rise = 0, m_fall = 0, m_flags = 0, m_snap = 0, m_rd = 0;
    logic       m_sum = 0;

    always @(posedge clk) begin
        logic [7:0] lvl, prv, clr, mism;
        lvl  = hist[1];
        prv  = hist[2];
        clr  = (wr_en && wr_addr == 2'd3) ? wr_data : 8'h00;
        mism = (lvl ^ m_snap) & (m_rise | m_fall);
        if (!rst_n) begin
            m_rise = 0; m_fall = 0; m_flags = 0; m_sum = 0; m_rd = 0; m_snap = lvl;
        end else begin
            if (rd_en) begin
                case (rd_addr)
                    2'd0: m_rd = lvl;
                    2'd1: m_rd = m_rise;
                    2'd2: m_rd = m_fall;
                    default: m_rd = legacy_mode ? {7'b0, m_sum} : m_flags;
                endcase
            end
            if (!legacy_mode)
                m_flags = (m_flags & ~clr) | (lvl & ~prv & m_rise) | (~lvl & prv & m_fall);
            else
                m_flags = m_flags & ~clr;
            m_sum = (m_sum & ~clr[0]) | (legacy_mode && mism != 0);
            if ((wr_en || rd_en) && ((wr_en && wr_addr == 2'd0) || (rd_en && rd_addr == 2'd0)))
                m_snap = lvl;
            if (wr_en && wr_addr == 2'd1) m_rise = wr_data;
            if (wr_en && wr_addr == 2'd2) m_fall = wr_data;
        end
        hist.push_front(pin_in);
        void'(hist.pop_back());
    end

    // per-clock comparison of the outputs with the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic exp_irq;
            exp_irq = irq_en && (legacy_mode ? m_sum : (m_flags != 0));
            checks++;
            if (irq !== exp_irq) begin
                errors++;
                $display("FAIL R6 model irq actual=%b expected=%b t=%0t", irq, exp_irq, $time);
            end
            checks++;
            if (rd_data !== m_rd) begin
                errors++;
                $display("FAIL R11 model rd_data actual=%h expected=%h t=%0t", rd_data, m_rd, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic pulse(input logic [7:0] v, input logic [7:0] back);
        set_pins(v);
        set_pins(back);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        // R7: state after reset
        chk_irq(1'b0, "R7");
        rd(2'd1, 8'h00, "R7");
        rd(2'd2, 8'h00, "R7");
        rd(2'd3, 8'h00, "R7");
        irq_en = 1'b1;

        // R1 / R3: rising on pin0 enabled, pin1 not
        wr(2'd1, 8'h01);
        set_pins(8'h03); tick(5);
        rd(2'd3, 8'h01, "R1 R3");
        chk_irq(1'b1, "R6");
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h00, "R5");

        // R2: falling on pin1; pin0 falling not enabled
        wr(2'd2, 8'h02);
        set_pins(8'h01); tick(5);
        rd(2'd3, 8'h02, "R2");
        wr(2'd3, 8'h02);
        set_pins(8'h00); tick(5);
        rd(2'd3, 8'h00, "R2 rise-only pin ignores fall");

        // R2: both transitions on pin2
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h06);
        set_pins(8'h04); tick(5);
        rd(2'd3, 8'h04, "R2 both rise");
        wr(2'd3, 8'h04);
        set_pins(8'h00); tick(5);
        rd(2'd3, 8'h04, "R2 both fall");
        wr(2'd3, 8'h04);

        // R4: single-cycle pulse on pin0 is kept
        pulse(8'h01, 8'h00); tick(5);
        rd(2'd3, 8'h01, "R4");
        chk_irq(1'b1, "R4");

        // R6: irq held until the last flag is cleared, gated by irq_en
        pulse(8'h04, 8'h00); tick(5);
        rd(2'd3, 8'h05, "R6");
        irq_en = 1'b0;
        chk_irq(1'b0, "R6 gate");
        irq_en = 1'b1;
        chk_irq(1'b1, "R6");
        wr(2'd3, 8'h01);
        chk_irq(1'b1, "R6 one flag left");
        wr(2'd3, 8'h04);
        chk_irq(1'b0, "R6 all cleared");

        // R5: set and clear on the same edge; the set wins
        pulse(8'h01, 8'h00); tick(5);
        @(negedge clk); pin_in = 8'h01;
        tick(2);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        rd(2'd3, 8'h01, "R5 set wins");
        wr(2'd3, 8'h01);
        set_pins(8'h00); tick(5);
        rd(2'd3, 8'h00, "R5");

        // legacy mode, mask pin4
        wr(2'd1, 8'h10);
        wr(2'd2, 8'h00);
        legacy_mode = 1'b1;
        tick(3);
        rd(2'd0, 8'h00, "R11 port");
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h00, "R8");
        set_pins(8'h10); tick(5);
        rd(2'd3, 8'h01, "R8 rising mismatch");
        chk_irq(1'b1, "R8");
        set_pins(8'h00); tick(5);
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h00, "R9 reverted mismatch gone");
        chk_irq(1'b0, "R9");
        set_pins(8'h10); tick(5);
        rd(2'd0, 8'h10, "R11 port");
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h00, "R9 reload");
        set_pins(8'h00); tick(5);
        rd(2'd3, 8'h01, "R8 falling mismatch");
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h01, "R9 clear blocked by mismatch");
        rd(2'd0, 8'h00, "R11 port");
        wr(2'd3, 8'h01);
        rd(2'd3, 8'h00, "R9 clear after reload");

        // R10: change between port read and summary clear is lost
        set_pins(8'h10); tick(5);
        chk_irq(1'b1, "R10 setup");
        rd(2'd0, 8'h10, "R10 port");
        pulse(8'h00, 8'h10); tick(5);
        wr(2'd3, 8'h01);
        tick(2);
        chk_irq(1'b0, "R10 change lost");
        rd(2'd3, 8'h00, "R10");

        // R11: mask read-back
        rd(2'd1, 8'h10, "R11 rise mask");
        rd(2'd2, 8'h00, "R11 fall mask");

        tick(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule